// File: doc/BRIEF.md
# Splittable Performance Event Counter Bank

This block counts hardware events for performance analysis. It holds a set of physical counters, 32 bits each. Software can split any one of them at run time into two independent 16-bit counters, so up to twice as many events can be tracked at once. Each logical counter chooses one line from a 64-bit event bus and can invert that line. It then counts either every clock cycle in which the line is high or only its rising edges.

Counting is qualified by several conditions. A global enable and a freeze control apply to the whole bank. A privilege filter compares a 2-bit mode input against a programmed mode. Each logical counter also has its own enable. When a counter increments past its largest value, it either wraps or holds at all-ones, and in both cases it sets a sticky overflow bit. The overflow bits are cleared by reading them, and a per-bit mask decides which of them drive the interrupt line.

Software reaches everything through a single-cycle word register port. Writes take effect at the next clock edge. Read data is combinational from the address.

Top module: `evc_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register map is: 0 global control, 1 overflow status, 2 interrupt mask, 4..7 physical counter values 0..3, 8..15 control words of logical counters 0..7. Any other address reads zero.
- R2: Global control keeps only these bits, and all other bits read zero:
  - bit 31: enable
  - bit 30: saturate
  - bits 24..21: split (physical counter n is split by bit 24−n)
  - bit 20: freeze
  - bits 19:18: mode

  A logical control word keeps only these bits:
  - bits 31:26: event select
  - bit 24: invert
  - bit 23: count-cycles
  - bit 22: enable

  Writes to the status address change nothing.
- R3: A logical counter advances only when all of these hold: global enable is 1, freeze is 0, its own enable is 1, and either mode equals 3 or mode equals `priv`. The mode encodings are 0 supervisor, 1 hypervisor, 2 user, 3 all.
- R4: The conditioned event is `events[select]` XOR invert.
- R5: With count-cycles set, the counter adds one on each clock edge where the conditioned event is high. With it clear, it adds one only where the event is high and was low at the previous edge.
- R6: With the split bit set, logical counter n uses bits 15:0 of physical counter n and logical counter n+4 uses bits 31:16, with no carry between them. With the split bit clear, logical counter n drives all 32 bits and logical counter n+4 never counts nor sets its status.
- R7: An increment applied to an all-ones counter (0xFFFF in a half, 0xFFFFFFFF in full width) wraps it to zero when saturate is 0. The overflow of logical counter c sets status bit 31−c.
- R8: With saturate set, that increment leaves the counter at all-ones and still sets the overflow bit.
- R9: A read of the status address with `reg_re` clears all status bits at the following edge. An overflow arriving at that same edge stays set.
- R10: `irq` is high exactly when some status bit 31−c is set and mask bit 31−c is also set.
- R11: A write to a physical counter takes priority over an increment at the same edge. The counter takes the written value and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (read-clears status) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| events | input | 64 | Event lines |
| priv | input | 2 | Current privilege mode |
| irq | output | 1 | Interrupt, OR of masked status bits |

## Verification
Two pairs of functions can collide at one clock edge. The first pair is a software write to a counter and an increment of that same counter. The second pair is a status read-clear and a fresh overflow. Both collisions are provoked directly: a counter is loaded with 0xFFFF while it counts every cycle, and the status read-clear is issued in exactly the cycle of the wrap. The result is judged by reading back the written value unchanged and the overflow bit still set. Constrained random phases repeat both collisions many times, and a cycle-level bench model that predicts every register decides the result.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NPHYS = 4;
  localparam int NLOG  = 2 * NPHYS;
  localparam int CW    = 32;
  localparam int HW    = CW / 2;
  localparam int NEV   = 64;
  localparam int SELW  = $clog2(NEV);
  localparam int AW    = 5;

  localparam int A_GCTL = 0;
  localparam int A_STAT = 1;
  localparam int A_MASK = 2;
  localparam int A_CNT0 = 4;
  localparam int A_CTL0 = 8;

  localparam int B_GEN   = 31;
  localparam int B_SAT   = 30;
  localparam int B_SPLIT = 24;
  localparam int B_FRZ   = 20;
  localparam int B_MODE  = 18;
  localparam int B_SEL   = 26;
  localparam int B_POL   = 24;
  localparam int B_CYC   = 23;
  localparam int B_EN    = 22;

  localparam logic [1:0] MODE_ALL = 2'd3;

  typedef struct packed {
    logic [SELW-1:0] sel;
    logic            pol;
    logic            cyc;
    logic            en;
  } ctl_t;
endpackage

// File: rtl/evc_cond.sv
module evc_cond
  import evc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] events,
  input  ctl_t           ctl,
  output logic           hit
);
  logic lvl;
  logic prev_q;

  always_comb begin
    lvl = events[ctl.sel] ^ ctl.pol;
    hit = ctl.cyc ? lvl : (lvl & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end
endmodule

// File: rtl/evc_phys.sv
module evc_phys #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         split,
  input  logic         sat,
  input  logic         req_lo,
  input  logic         req_hi,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         ovf_lo,
  output logic         ovf_hi
);
  localparam int H = W / 2;

  logic [W-1:0] cnt_q, cnt_d;
  logic         upd;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    if (wr) begin
      cnt_d = wdata;
    end else if (split) begin
      if (req_lo) begin
        if (&cnt_q[H-1:0]) begin
          ovf_lo       = 1'b1;
          cnt_d[H-1:0] = sat ? {H{1'b1}} : '0;
        end else begin
          cnt_d[H-1:0] = cnt_q[H-1:0] + 1'b1;
        end
      end
      if (req_hi) begin
        if (&cnt_q[W-1:H]) begin
          ovf_hi       = 1'b1;
          cnt_d[W-1:H] = sat ? {H{1'b1}} : '0;
        end else begin
          cnt_d[W-1:H] = cnt_q[W-1:H] + 1'b1;
        end
      end
    end else if (req_lo) begin
      if (&cnt_q) begin
        ovf_lo = 1'b1;
        cnt_d  = sat ? {W{1'b1}} : '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    upd = wr | req_lo | (split & req_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  input  logic [NEV-1:0] events,
  input  logic [1:0]     priv,
  output logic           irq
);
  // reset synchroniser: asserts at once, releases on the second edge
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  logic                gen_q, sat_q, frz_q;
  logic [1:0]          mode_q;
  logic [NPHYS-1:0]    split_q;
  logic [NLOG-1:0]     mask_q, st_q, st_d, ovf_set, hit, req;
  ctl_t                ctl_q [NLOG];
  logic [CW-1:0]       cnt [NPHYS];
  logic [NPHYS*CW-1:0] cnt_flat;
  logic [NPHYS-1:0]    ctr_wr;
  logic [NLOG-1:0]     wr_c;
  logic                wr_g, wr_m, clr, gate;

  // address decode
  always_comb begin
    wr_g = reg_we && (reg_addr == AW'(A_GCTL));
    wr_m = reg_we && (reg_addr == AW'(A_MASK));
    clr  = reg_re && (reg_addr == AW'(A_STAT));
    for (int p = 0; p < NPHYS; p++) ctr_wr[p] = reg_we && (reg_addr == AW'(A_CNT0 + p));
    for (int l = 0; l < NLOG; l++)  wr_c[l]   = reg_we && (reg_addr == AW'(A_CTL0 + l));
  end

  // global control
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gen_q   <= 1'b0;
      sat_q   <= 1'b0;
      frz_q   <= 1'b0;
      mode_q  <= '0;
      split_q <= '0;
    end else if (wr_g) begin
      gen_q  <= reg_wdata[B_GEN];
      sat_q  <= reg_wdata[B_SAT];
      frz_q  <= reg_wdata[B_FRZ];
      mode_q <= reg_wdata[B_MODE +: 2];
      for (int p = 0; p < NPHYS; p++) split_q[p] <= reg_wdata[B_SPLIT - p];
    end
  end

  // interrupt mask
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) mask_q <= '0;
    else if (wr_m) begin
      for (int l = 0; l < NLOG; l++) mask_q[l] <= reg_wdata[CW-1-l];
    end
  end

  // counting qualifier shared by all logical counters
  always_comb gate = gen_q & ~frz_q & ((mode_q == MODE_ALL) || (mode_q == priv));

  for (genvar l = 0; l < NLOG; l++) begin : g_log
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) ctl_q[l] <= '0;
      else if (wr_c[l]) begin
        ctl_q[l].sel <= reg_wdata[B_SEL +: SELW];
        ctl_q[l].pol <= reg_wdata[B_POL];
        ctl_q[l].cyc <= reg_wdata[B_CYC];
        ctl_q[l].en  <= reg_wdata[B_EN];
      end
    end

    evc_cond u_cond (
      .clk    (clk),
      .rst_n  (rst_q),
      .events (events),
      .ctl    (ctl_q[l]),
      .hit    (hit[l])
    );

    assign req[l] = gate & ctl_q[l].en & hit[l];
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_phys
    evc_phys #(.W(CW)) u_phys (
      .clk    (clk),
      .rst_n  (rst_q),
      .split  (split_q[p]),
      .sat    (sat_q),
      .req_lo (req[p]),
      .req_hi (req[p+NPHYS]),
      .wr     (ctr_wr[p]),
      .wdata  (reg_wdata),
      .cnt    (cnt[p]),
      .ovf_lo (ovf_set[p]),
      .ovf_hi (ovf_set[p+NPHYS])
    );
    assign cnt_flat[p*CW +: CW] = cnt[p];
  end

  // sticky status: a new overflow wins over a read-clear
  always_comb st_d = (clr ? '0 : st_q) | ovf_set;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= '0;
    else        st_q <= st_d;
  end

  assign irq = |(st_q & mask_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_GCTL)) begin
      reg_rdata[B_GEN]        = gen_q;
      reg_rdata[B_SAT]        = sat_q;
      reg_rdata[B_FRZ]        = frz_q;
      reg_rdata[B_MODE +: 2]  = mode_q;
      for (int p = 0; p < NPHYS; p++) reg_rdata[B_SPLIT - p] = split_q[p];
    end else if (reg_addr == AW'(A_STAT)) begin
      for (int l = 0; l < NLOG; l++) reg_rdata[CW-1-l] = st_q[l];
    end else if (reg_addr == AW'(A_MASK)) begin
      for (int l = 0; l < NLOG; l++) reg_rdata[CW-1-l] = mask_q[l];
    end else begin
      for (int p = 0; p < NPHYS; p++)
        if (reg_addr == AW'(A_CNT0 + p)) reg_rdata = cnt[p];
      for (int l = 0; l < NLOG; l++)
        if (reg_addr == AW'(A_CTL0 + l)) begin
          reg_rdata[B_SEL +: SELW] = ctl_q[l].sel;
          reg_rdata[B_POL]         = ctl_q[l].pol;
          reg_rdata[B_CYC]         = ctl_q[l].cyc;
          reg_rdata[B_EN]          = ctl_q[l].en;
        end
    end
  end
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                gen,
  input logic                frz,
  input logic                sat,
  input logic [NPHYS-1:0]    split,
  input logic [NPHYS-1:0]    ctr_wr,
  input logic [NPHYS*CW-1:0] cnt_flat,
  input logic [NLOG-1:0]     st,
  input logic                clr
);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gen || frz) && (ctr_wr == '0)) |=> $stable(cnt_flat));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st) & ~st)) |-> $past(clr));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !split[0] && (&cnt_flat[CW-1:0]) && !ctr_wr[0]) |=> (&cnt_flat[CW-1:0]));

  // R6
  upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split[0] && !st[NPHYS]) |=> !st[NPHYS]);
endmodule

bind evc_bank evc_bank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .gen      (gen_q),
  .frz      (frz_q),
  .sat      (sat_q),
  .split    (split_q),
  .ctr_wr   (ctr_wr),
  .cnt_flat (cnt_flat),
  .st       (st_q),
  .clr      (clr)
);

// File: tb/evc_bank_test.sv
`timescale 1ns/1ps
module evc_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we, re;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic [63:0] events;
  logic [1:0]  priv;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  evc_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .events(events), .priv(priv), .irq(irq)
  );

  // cycle-level reference model built from the requirements
  logic [31:0] m_gc, m_cnt [4], m_ctl [8], v;
  logic [7:0]  m_st, m_mask, rq, sets;
  logic        m_prev [8];
  logic        lvl, gate, sat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gc = 0; m_st = 0; m_mask = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      for (int i = 0; i < 8; i++) begin m_ctl[i] = 0; m_prev[i] = 0; end
    end else begin
      gate = m_gc[31] && !m_gc[20] && (m_gc[19:18] == 2'd3 || m_gc[19:18] == priv);
      sat  = m_gc[30];
      sets = 0;
      for (int l = 0; l < 8; l++) begin
        lvl   = events[m_ctl[l][31:26]] ^ m_ctl[l][24];
        rq[l] = gate && m_ctl[l][22] && (m_ctl[l][23] ? lvl : (lvl && !m_prev[l]));
        m_prev[l] = lvl;
      end
      for (int p = 0; p < 4; p++) begin
        v = m_cnt[p];
        if (we && addr == 5'(4 + p)) v = wdata;
        else if (m_gc[24-p]) begin
          if (rq[p]) begin
            if (v[15:0] == 16'hFFFF) begin sets[p] = 1; v[15:0] = sat ? 16'hFFFF : 16'h0; end
            else v[15:0] = v[15:0] + 16'd1;
          end
          if (rq[p+4]) begin
            if (v[31:16] == 16'hFFFF) begin sets[p+4] = 1; v[31:16] = sat ? 16'hFFFF : 16'h0; end
            else v[31:16] = v[31:16] + 16'd1;
          end
        end else if (rq[p]) begin
          if (v == 32'hFFFF_FFFF) begin sets[p] = 1; v = sat ? 32'hFFFF_FFFF : 32'h0; end
          else v = v + 32'd1;
        end
        m_cnt[p] = v;
      end
      m_st = ((re && addr == 5'd1) ? 8'h0 : m_st) | sets;
      if (we && addr == 5'd0) m_gc = wdata & 32'hC1FC_0000;
      if (we && addr == 5'd2) for (int l = 0; l < 8; l++) m_mask[l] = wdata[31-l];
      if (we && addr >= 5'd8) m_ctl[addr-5'd8] = wdata & 32'hFDC0_0000;
    end
  end

  function automatic logic [31:0] exp_rd(input int a);
    logic [31:0] r = 0;
    if (a == 0) r = m_gc;
    else if (a == 1) for (int l = 0; l < 8; l++) r[31-l] = m_st[l];
    else if (a == 2) for (int l = 0; l < 8; l++) r[31-l] = m_mask[l];
    else if (a >= 4 && a < 8) r = m_cnt[a-4];
    else if (a >= 8 && a < 16) r = m_ctl[a-8];
    return r;
  endfunction

  function automatic logic exp_irq();
    return |(m_st & m_mask);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = 5'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, input bit c, output logic [31:0] q);
    addr = 5'(a); re = c; #1 q = rdata;
    if (c) begin @(negedge clk); re = 0; end
  endtask

  task automatic cmp_all(input string tag);
    logic [31:0] q;
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      if (a == 3) continue;
      rd(a, 0, q);
      check($sformatf("%s addr%0d", tag, a), q, exp_rd(a));
    end
    check({tag, " irq R10"}, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, g, pre;
    void'($urandom(32'd4711));
    rst_n = 0; we = 0; re = 0; addr = 0; wdata = 0; events = 0; priv = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, 0, q);
      check($sformatf("R1 reset addr%0d", a), q, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 field storage
    wr(0, 32'hFFFF_FFFF); rd(0, 0, q); check("R2 gctl mask", q, 32'hC1FC_0000);
    wr(0, 32'h0);
    wr(11, 32'hFFFF_FFFF); rd(11, 0, q); check("R2 ctl mask", q, 32'hFDC0_0000);
    wr(11, 32'h0);
    wr(1, 32'hFFFF_FFFF); rd(1, 0, q); check("R2 status write ignored", q, 32'h0);
    rd(20, 0, q); check("R1 unmapped", q, 32'h0);

    // R3 privilege filter
    priv = 2'd2;
    wr(0, 32'h8104_0000);          // enable, split0, mode 1
    wr(8, 32'h01C0_0000);          // sel0 inverted, cycles, enable
    wr(4, 32'h0);
    repeat (5) @(negedge clk);
    rd(4, 0, q); check("R3 mode mismatch", q, 32'h0);
    priv = 2'd1;
    repeat (5) @(negedge clk);
    rd(4, 0, q); check("R3 mode match", q, 32'd5);
    wr(8, 32'h0);

    // R5 edge vs cycle counting, R6 halves
    wr(0, 32'h81EC_0000);          // enable, all split, mode 3
    wr(9, 32'h1440_0000);          // sel5 edge
    wr(10, 32'h14C0_0000);         // sel5 cycles
    wr(5, 32'h0); wr(6, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); events[5] = 1;
      @(negedge clk);
      @(negedge clk); events[5] = 0;
    end
    @(negedge clk);
    rd(5, 0, q); check("R5 edge count", q, 32'd3);
    rd(6, 0, q); check("R5 cycle count R6 high half idle", q, 32'd6);

    // R4 polarity
    wr(11, 32'h15C0_0000);         // sel5 inverted, cycles
    wr(7, 32'h0);
    repeat (4) @(negedge clk);
    rd(7, 0, q); check("R4 inverted event", q, 32'd4);
    wr(9, 0); wr(10, 0); wr(11, 0);

    // R11 write priority, R7 wrap, R9 clear vs set collision, R10 irq
    wr(0, 32'h810C_0000);          // enable, split0, mode 3
    wr(8, 32'h01C0_0000);
    rd(1, 1, q);
    wr(4, 32'h0000_FFFF);
    rd(4, 0, q); check("R11 write wins", q, 32'h0000_FFFF);
    rd(1, 1, q);                   // clear at the wrap edge
    rd(1, 0, q); check("R9 set beats clear", q, 32'h8000_0000);
    rd(4, 0, q); check("R7 wrap half", q, 32'h0);
    check("R10 masked off", {31'b0, irq}, 32'h0);
    wr(2, 32'h8000_0000);
    check("R10 unmasked", {31'b0, irq}, 32'h1);
    rd(1, 1, q);
    rd(1, 0, q); check("R9 cleared", q, 32'h0);

    // R8 saturation in full width
    wr(0, 32'hC00C_0000);          // enable, saturate, unsplit, mode 3
    wr(4, 32'hFFFF_FFFD);
    repeat (4) @(negedge clk);
    rd(4, 0, q); check("R8 hold at max", q, 32'hFFFF_FFFF);
    rd(1, 0, q); check("R8 R6 overflow bit", q, 32'h8000_0000);
    cmp_all("R2 R8 directed");

    // constrained random phases
    for (int it = 0; it < 24; it++) begin
      g = 0;
      g[31] = ($urandom % 8) != 0;
      g[30] = 1'($urandom);
      g[24:21] = 4'($urandom);
      g[20] = ($urandom % 8) == 0;
      g[19:18] = 2'($urandom);
      wr(0, g);
      for (int l = 0; l < 8; l++) wr(8 + l, $urandom);
      for (int p = 0; p < 4; p++) begin
        pre = $urandom;
        if ($urandom % 3 != 0) pre = {12'hFFF, pre[19:16], 12'hFFF, pre[3:0]};
        wr(4 + p, pre);
      end
      wr(2, $urandom);
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        events = {$urandom, $urandom};
        priv = 2'($urandom);
        we = ($urandom % 20) == 0;
        re = !we && (($urandom % 6) == 0);
        if (we) begin addr = 5'(4 + $urandom % 4); wdata = $urandom; end
        else addr = 5'd1;
      end
      @(negedge clk); we = 0; re = 0;
      cmp_all($sformatf("R3 R4 R5 R6 R7 R8 R9 R11 rand%0d", it));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule